// File: doc/BRIEF.md
# Slave-Mode Parallel Programming Interface

This block lets an external programmer load and read back an on-chip memory whose cells can only be programmed from the erased state (all ones) towards zero. The programmer shares one 16-bit parallel port between address and data. A falling edge on the address strobe captures a word-aligned address together with an operation bit. A falling edge on the program strobe then either writes the port word at that address or reads the stored word back. A falling edge on the step strobe moves the address on by one word, so a run of consecutive locations needs only one address phase.

Each write is read back from the array and compared with the intended word. Two flags report the outcome. One flag shows the result of the most recent write. The other stays set only while every write since reset has matched. The array is modelled inside the block as a register file that takes a fixed number of clocks per write. It sits behind a request/acknowledge handshake. While an array operation is outstanding, the block reports busy. It rejects and flags any strobe that arrives during that time. After reset, all strobes are ignored until a settling interval has elapsed.

Top module: `prog_slave_if`

## Requirements
- R1: A falling edge on `addr_stb_n` latches the address from `port_in[15:1]` (bit 0 of the address is forced to 0) and the operation from `port_in[0]`: 1 selects program mode, 0 selects dump mode.
- R2: In program mode, a falling edge on `prog_stb_n` writes `port_in` to the word at the latched address. The array resets to all ones, and a write can only clear bits, so the stored word becomes old AND new.
- R3: In dump mode, a falling edge on `prog_stb_n` reads the addressed word. While the strobe is held low, `port_oe` is 1 and `port_out` carries the word. `port_oe` returns to 0 within 4 clocks after the strobe rises.
- R4: A falling edge on `inc_n` advances the latched address by 2 bytes (one word).
- R5: `verify_ok` is cleared when a write starts. Once that write completes, it is 1 exactly when the read-back word equals the written word. It is valid no later than WRITE_CLKS+6 clocks after `prog_stb_n` rises.
- R6: `cum_ok` is 1 after reset. It is cleared by any write whose read-back mismatches, and it stays 0 until the next reset.
- R7: All three strobes are ignored until SETTLE_CLKS clocks have passed with reset deasserted. An ignored strobe changes neither the array nor the flags.
- R8: `busy` is 1 while an array operation is outstanding. A strobe falling edge during that time is ignored and sets `err`. `err` is cleared by the next accepted address strobe.
- R9: During reset, `busy`, `err`, `verify_ok` and `port_oe` are 0 and `cum_ok` is 1.
- R10: `port_oe` is never 1 while program mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_in | input | 16 | Shared port as driven by the programmer (address/operation or data) |
| port_out | output | 16 | Word read back in dump mode, 0 otherwise |
| port_oe | output | 1 | Block drives the shared port |
| addr_stb_n | input | 1 | Address/operation latch strobe, acts on falling edge |
| prog_stb_n | input | 1 | Program/read strobe, acts on falling edge |
| inc_n | input | 1 | Address step strobe, acts on falling edge |
| verify_ok | output | 1 | Last write read back correctly |
| cum_ok | output | 1 | Every write since reset read back correctly |
| busy | output | 1 | Array operation outstanding |
| err | output | 1 | Strobe arrived while busy |

## Verification
A wrong latched address or step count has no flag of its own. It shows up only when a later dump returns a word from the wrong location, or when a follow-on write lands on a neighbour. For that reason the bench always reads back the locations next to the target. A wrong array merge rule or compare appears at `verify_ok` within one write time. A `cum_ok` that clears at the wrong time is never corrected before reset, so every later check exposes it. A busy window that ends too early lets an overlapping strobe through. That appears as a missing `err` at the end of the same operation, and as a displaced word at the next dump.

// File: rtl/prog_pkg.sv
// Package: shared operation encoding and strobe indices for the programming
// interface. Assumes exactly three strobes in the fixed order below.
package prog_pkg;
    typedef enum logic {
        OP_DUMP = 1'b0,
        OP_PROG = 1'b1
    } prog_op_e;

    localparam int STB_ADDR = 0;
    localparam int STB_DATA = 1;
    localparam int STB_STEP = 2;
    localparam int NUM_STB  = 3;
endpackage

// File: rtl/prog_stb_sync.sv
// Module: brings N active-low asynchronous strobes into the clock domain
// through two flops and flags each falling edge for one clock.
// Assumes strobes idle high and every low or high phase lasts at least two clocks.
module prog_stb_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stb_n,
    output logic [N-1:0] lvl,
    output logic [N-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stb
            logic meta_q, sync_q, prev_q;
            // Two-stage synchronizer plus a history flop for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b1;
                    sync_q <= 1'b1;
                    prev_q <= 1'b1;
                end else begin
                    meta_q <= stb_n[g];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end
            assign lvl[g]  = sync_q;
            assign fall[g] = prev_q & ~sync_q;
        end
    endgenerate
endmodule

// File: rtl/prog_array.sv
// Module: behavioural model of a program-once memory array. Reset erases
// every word to all ones. A write ANDs the new word into the stored word, so
// only bits that are 1 can be cleared. It acknowledges a write after
// WRITE_CLKS clocks and a read after one clock, returning the (new) stored
// word. Assumes one request at a time.
module prog_array #(
    parameter int W          = 16,
    parameter int DEPTH      = 64,
    parameter int WRITE_CLKS = 8,
    localparam int IW        = $clog2(DEPTH),
    localparam int CW        = $clog2(WRITE_CLKS + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic          ack,
    output logic [W-1:0]  rdata
);
    logic [W-1:0]  cells [DEPTH];
    logic          pend_q, we_q;
    logic [IW-1:0] idx_q;
    logic [W-1:0]  wd_q;
    logic [CW-1:0] cnt_q;

    // Accept a request, count down its latency, then perform it and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
            pend_q <= 1'b0;
            we_q   <= 1'b0;
            idx_q  <= '0;
            wd_q   <= '0;
            cnt_q  <= '0;
            ack    <= 1'b0;
            rdata  <= '0;
        end else begin
            ack <= 1'b0;
            if (!pend_q && req) begin
                pend_q <= 1'b1;
                we_q   <= we;
                idx_q  <= idx;
                wd_q   <= wdata;
                cnt_q  <= we ? CW'(WRITE_CLKS) : CW'(1);
            end else if (pend_q) begin
                if (cnt_q <= CW'(1)) begin
                    pend_q <= 1'b0;
                    ack    <= 1'b1;
                    if (we_q) begin
                        cells[idx_q] <= cells[idx_q] & wd_q;
                        rdata        <= cells[idx_q] & wd_q;
                    end else begin
                        rdata <= cells[idx_q];
                    end
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

    // R8
    ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !ack);
endmodule

// File: rtl/prog_ctrl.sv
// Module: sequencing for the programming interface. It waits out the
// settling interval, latches address/operation and data, steps the address,
// issues array requests, tracks busy, error and both verify flags, and holds
// read-back data for the shared port. Assumes the strobe edges are already
// synchronous one-clock pulses.
module prog_ctrl
    import prog_pkg::*;
#(
    parameter int W           = 16,
    parameter int SETTLE_CLKS = 1100,
    parameter int WRITE_CLKS  = 8,
    localparam int SCW        = $clog2(SETTLE_CLKS + 2),
    localparam int BCW        = $clog2(WRITE_CLKS + 8) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       port_in,
    input  logic [NUM_STB-1:0] fall,
    input  logic               data_lvl,
    output logic               mem_req,
    output logic               mem_we,
    output logic [W-1:0]       mem_addr,
    output logic [W-1:0]       mem_wdata,
    input  logic               mem_ack,
    input  logic [W-1:0]       mem_rdata,
    output logic [W-1:0]       port_out,
    output logic               port_oe,
    output logic               verify_ok,
    output logic               cum_ok,
    output logic               busy,
    output logic               err
);
    logic [SCW-1:0] settle_q;
    logic           ready;
    logic [W-1:0]   addr_q, wdata_q, dout_q;
    prog_op_e       op_q;
    logic           op_write_q, dump_vld_q;

    assign ready = (settle_q >= SCW'(SETTLE_CLKS));

    // Main sequencer: settle count, strobe decode, array handshake, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q   <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            dout_q     <= '0;
            op_q       <= OP_DUMP;
            op_write_q <= 1'b0;
            dump_vld_q <= 1'b0;
            mem_req    <= 1'b0;
            busy       <= 1'b0;
            err        <= 1'b0;
            verify_ok  <= 1'b0;
            cum_ok     <= 1'b1;
        end else begin
            mem_req <= 1'b0;
            if (!ready) settle_q <= settle_q + SCW'(1);
            if (ready) begin
                if (busy) begin
                    if (|fall) err <= 1'b1;
                    if (mem_ack) begin
                        busy <= 1'b0;
                        if (op_write_q) begin
                            verify_ok <= (mem_rdata == wdata_q);
                            if (mem_rdata != wdata_q) cum_ok <= 1'b0;
                        end else begin
                            dout_q     <= mem_rdata;
                            dump_vld_q <= 1'b1;
                        end
                    end
                end else if (fall[STB_ADDR]) begin
                    addr_q     <= {port_in[W-1:1], 1'b0};
                    op_q       <= prog_op_e'(port_in[0]);
                    err        <= 1'b0;
                    dump_vld_q <= 1'b0;
                end else if (fall[STB_DATA]) begin
                    busy       <= 1'b1;
                    mem_req    <= 1'b1;
                    op_write_q <= (op_q == OP_PROG);
                    if (op_q == OP_PROG) begin
                        wdata_q   <= port_in;
                        verify_ok <= 1'b0;
                    end
                end else if (fall[STB_STEP]) begin
                    addr_q <= addr_q + W'(2);
                end
            end
            if (data_lvl) dump_vld_q <= 1'b0;
        end
    end

    assign mem_we    = op_write_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign port_oe   = dump_vld_q;
    assign port_out  = dump_vld_q ? dout_q : '0;

    // Busy-length counter used only by the bound check below.
    logic [BCW-1:0] busy_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len_q <= '0;
        else if (busy) busy_len_q <= busy_len_q + BCW'(1);
        else           busy_len_q <= '0;
    end

    // R10
    oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_oe |-> (op_q == OP_DUMP));
    // R6
    cum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(cum_ok));
    // R7
    settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !mem_req);
    // R8
    ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> busy);
    // R8
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len_q <= BCW'(WRITE_CLKS + 4));
    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy && fall == 3'b100) |=> (addr_q == $past(addr_q) + W'(2)));
endmodule

// File: rtl/prog_slave_if.sv
// Module: top of the programming interface. It joins the strobe synchronizer,
// the sequencer and the array model. The array word index is taken from the
// byte address above bit 0, modulo DEPTH. Assumes DEPTH is a power of two.
module prog_slave_if #(
    parameter int PORT_W      = 16,
    parameter int DEPTH       = 64,
    parameter int SETTLE_CLKS = 1100,
    parameter int WRITE_CLKS  = 8,
    localparam int IW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] port_out,
    output logic              port_oe,
    input  logic              addr_stb_n,
    input  logic              prog_stb_n,
    input  logic              inc_n,
    output logic              verify_ok,
    output logic              cum_ok,
    output logic              busy,
    output logic              err
);
    import prog_pkg::*;

    logic [NUM_STB-1:0] stb_lvl, stb_fall;
    logic               mem_req, mem_we, mem_ack;
    logic [PORT_W-1:0]  mem_addr, mem_wdata, mem_rdata;

    prog_stb_sync #(.N(NUM_STB)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_n ({inc_n, prog_stb_n, addr_stb_n}),
        .lvl   (stb_lvl),
        .fall  (stb_fall)
    );

    prog_ctrl #(
        .W           (PORT_W),
        .SETTLE_CLKS (SETTLE_CLKS),
        .WRITE_CLKS  (WRITE_CLKS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_in   (port_in),
        .fall      (stb_fall),
        .data_lvl  (stb_lvl[STB_DATA]),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .port_out  (port_out),
        .port_oe   (port_oe),
        .verify_ok (verify_ok),
        .cum_ok    (cum_ok),
        .busy      (busy),
        .err       (err)
    );

    prog_array #(
        .W          (PORT_W),
        .DEPTH      (DEPTH),
        .WRITE_CLKS (WRITE_CLKS)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mem_req),
        .we    (mem_we),
        .idx   (mem_addr[IW:1]),
        .wdata (mem_wdata),
        .ack   (mem_ack),
        .rdata (mem_rdata)
    );
endmodule

// File: tb/prog_slave_if_tb.sv
module prog_slave_if_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int WCLK       = 8;
    localparam int SETTLE     = 1100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] port_in = '0;
    logic [15:0] port_out;
    logic        port_oe, verify_ok, cum_ok, busy, err;
    logic        addr_stb_n = 1'b1, prog_stb_n = 1'b1, inc_n = 1'b1;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [DEPTH];
    logic [15:0] cur_addr = '0;
    logic        model_cum = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_slave_if #(.DEPTH(DEPTH), .SETTLE_CLKS(SETTLE), .WRITE_CLKS(WCLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .port_out(port_out),
        .port_oe(port_oe), .addr_stb_n(addr_stb_n), .prog_stb_n(prog_stb_n),
        .inc_n(inc_n), .verify_ok(verify_ok), .cum_ok(cum_ok), .busy(busy), .err(err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int widx(input logic [15:0] a);
        return int'(a[6:1]);
    endfunction

    function automatic logic exp_write_ok(input logic [15:0] old, input logic [15:0] d);
        return ((old & d) == d);
    endfunction

    task automatic addr_phase(input logic [15:0] a, input logic prog_mode);
        port_in = {a[15:1], prog_mode};
        addr_stb_n = 1'b0; step(4);
        addr_stb_n = 1'b1; step(4);
    endtask

    task automatic step_addr();
        inc_n = 1'b0; step(4);
        inc_n = 1'b1; step(4);
    endtask

    // Program one word at cur_addr and check the verify flags (R2, R5, R6).
    task automatic write_word(input logic [15:0] d);
        int i;
        logic okx;
        i = widx(cur_addr);
        okx = exp_write_ok(model[i], d);
        model[i] = model[i] & d;
        if (!okx) model_cum = 1'b0;
        port_in = d;
        prog_stb_n = 1'b0; step(8);
        prog_stb_n = 1'b1; step(WCLK + 6);
        chk(verify_ok == okx, "R5 verify", {15'd0, verify_ok}, {15'd0, okx});
        chk(cum_ok == model_cum, "R6 cumulative", {15'd0, cum_ok}, {15'd0, model_cum});
    endtask

    // Read one word at cur_addr and check the port (R3, R2).
    task automatic dump_word();
        logic [15:0] e;
        e = model[widx(cur_addr)];
        prog_stb_n = 1'b0; step(8);
        chk(port_oe == 1'b1, "R3 oe during read", {15'd0, port_oe}, 16'd1);
        chk(port_out == e, "R3 dump data", port_out, e);
        prog_stb_n = 1'b1; step(4);
        chk(port_oe == 1'b0, "R3 oe released", {15'd0, port_oe}, 16'd0);
        step(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        step(5);
        // R9 reset values
        chk(busy == 0, "R9 busy", {15'd0, busy}, 16'd0);
        chk(err == 0, "R9 err", {15'd0, err}, 16'd0);
        chk(verify_ok == 0, "R9 verify", {15'd0, verify_ok}, 16'd0);
        chk(cum_ok == 1, "R9 cum", {15'd0, cum_ok}, 16'd1);
        chk(port_oe == 0, "R9 oe", {15'd0, port_oe}, 16'd0);
        rst_n = 1'b1;
        step(50);
        // R7 strobes before settling are ignored: no write, no busy
        addr_phase(16'h0010, 1'b1);
        port_in = 16'h0000;
        prog_stb_n = 1'b0; step(4);
        chk(busy == 0, "R7 no busy before settle", {15'd0, busy}, 16'd0);
        prog_stb_n = 1'b1; step(4);
        chk(verify_ok == 0, "R7 verify untouched", {15'd0, verify_ok}, 16'd0);
        step_addr();
        step(SETTLE);
        // R1 dump mode at 0x0010 shows erased word (early write dropped, R7)
        cur_addr = 16'h0010;
        addr_phase(cur_addr, 1'b0);
        dump_word();
        // R1 R2 passing writes
        addr_phase(16'h0020, 1'b1); cur_addr = 16'h0020;
        write_word(16'hA5F0);
        write_word(16'h0550);
        // R4 step and write neighbour
        step_addr(); cur_addr = cur_addr + 16'd2;
        write_word(16'h1234);
        // R6 failing write: tries to set bits already cleared
        addr_phase(16'h0020, 1'b1); cur_addr = 16'h0020;
        write_word(16'hFFFF);
        // passing write after a failure: verify 1, cum stays 0
        write_word(16'h0400);
        // R3 R4 dump with stepping
        addr_phase(16'h0020, 1'b0); cur_addr = 16'h0020;
        dump_word();
        step_addr(); cur_addr = cur_addr + 16'd2;
        dump_word();
        step_addr(); cur_addr = cur_addr + 16'd2;
        dump_word();
        // R8 strobe during busy: step ignored, err set
        addr_phase(16'h0040, 1'b1); cur_addr = 16'h0040;
        model[widx(cur_addr)] = model[widx(cur_addr)] & 16'hF0F0;
        port_in = 16'hF0F0;
        prog_stb_n = 1'b0; step(5);
        chk(busy == 1, "R8 busy during write", {15'd0, busy}, 16'd1);
        inc_n = 1'b0; step(3); inc_n = 1'b1;
        prog_stb_n = 1'b1; step(WCLK + 6);
        chk(err == 1, "R8 err set", {15'd0, err}, 16'd1);
        chk(busy == 0, "R8 busy cleared", {15'd0, busy}, 16'd0);
        write_word(16'h3030);
        addr_phase(16'h0040, 1'b0);
        chk(err == 0, "R8 err cleared by address", {15'd0, err}, 16'd0);
        cur_addr = 16'h0040; dump_word();
        cur_addr = 16'h0042; addr_phase(cur_addr, 1'b0); dump_word();
        // randomized operations
        for (int k = 0; k < 120; k++) begin
            int op;
            logic [15:0] d;
            op = int'($urandom_range(2, 0));
            cur_addr = 16'(($urandom_range(DEPTH - 1, 0)) * 2);
            d = 16'($urandom);
            if (op == 0) begin
                addr_phase(cur_addr, 1'b1);
                if ($urandom_range(3, 0) != 0) d = d & model[widx(cur_addr)];
                write_word(d);
            end else if (op == 1) begin
                addr_phase(cur_addr, 1'b0);
                dump_word();
            end else begin
                addr_phase(cur_addr, 1'b1);
                write_word(d & model[widx(cur_addr)]);
                step_addr(); cur_addr = cur_addr + 16'd2;
                write_word(d);
            end
        end
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule